// File: doc/BRIEF.md
# Compare Timer with Prescaler

This block is a 32-bit up-counting timer that software reaches through a small word-addressed register bus. A clock-select field starts and stops the count. A power-of-two prescaler sets how many clock cycles pass between increments. A limit register decides where the count wraps back to zero. A single compare channel watches the count and latches a match flag when the count equals a programmed value. The match flag drives a level interrupt when the channel's interrupt enable is set.

The bus has no back-pressure. A request is taken in every cycle in which `req_valid` is high, and no ready signal exists. A write updates its register at that clock edge. A read returns its data on `rsp_data` with `rsp_valid` high exactly one cycle later, and the requester must accept it in that cycle. Software counts free time by reading the counter. It arms an event by writing the channel value and enabling the channel in compare mode. It services the event by writing one to the flag bit.

Top module: `cmp_timer`

## Requirements
- R1: Registers are decoded at byte offsets 0x10 (control), 0x14 (count), 0x18 (limit), 0x1C (status), 0x20 (channel control) and 0x24 (channel value). A read at any other offset returns 0. Read data appears with `rsp_valid` one cycle after the request.
- R2: After reset every register reads 0, the count is stopped, the channel is off and `irq` is low.
- R3: Control bits 4:3 select the clock. Only the value 01 advances the count. Any other value holds the count and restarts the prescale phase.
- R4: Control bits 2:0 hold an exponent p. The phase counter advances on each enabled cycle. A tick is issued when the phase counter is at or above 2^p-1, and the phase then restarts, so p=3 gives one increment per 8 cycles.
- R5: On a tick the count increments, except that it returns to 0 when it equals the limit. A limit of 0xFFFF_FFFF gives the full 32-bit range.
- R6: Any write to the count register sets the count and the prescale phase to 0, whatever data is written. This takes priority over a tick in the same cycle.
- R7: Channel control bits 5:2 form a mode field. Only the value 4'h4 enables compare, and every other value turns the channel off. The match flag sets at the edge of a tick taken while the count equals the channel value and the channel is enabled.
- R8: Status bit 0 is the match flag. Writing 1 there clears it and writing 0 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R9: `irq` is high exactly while the match flag and channel control bit 6 (interrupt enable) are both set.
- R10: A write to the channel value is used from the next cycle on. A value below the current count matches only after the count wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt from the channel |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a compare match and a software clear of the flag land on one edge. In the second, a count-register write lands on the edge of a prescaler tick. Both are forced directly by setting the limit and the channel value to 0 with no prescaling. The count then sits at zero and matches on every cycle, so every clear and every count write collides with a match or a tick. Random traffic adds more collisions. A bench model applies the stated priorities, the set winning over the clear and the count write winning over the tick. It then judges each read of the status and count registers and the `irq` level in every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PSC_W = 3;

  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_CNT  = 8'h14;
  localparam logic [7:0] OFS_LIM  = 8'h18;
  localparam logic [7:0] OFS_STAT = 8'h1C;
  localparam logic [7:0] OFS_CHC  = 8'h20;
  localparam logic [7:0] OFS_CHV  = 8'h24;

  localparam logic [1:0] CLKSEL_PRESCALED = 2'b01;
  localparam logic [3:0] CHMODE_SWCMP     = 4'h4;

  typedef struct packed {
    logic [1:0]       clksel;
    logic [PSC_W-1:0] psc;
  } ctrl_t;

  typedef struct packed {
    logic       irq_en;
    logic [3:0] mode;
  } chctl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int CHC_W  = $bits(chctl_t);
  localparam int CHC_LSB = 2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int EXP_W = PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [EXP_W-1:0] psc,
  output logic             tick
);
  localparam int PH_W = (1 << EXP_W) - 1;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] limit;

  assign limit = (PH_W'(1) << psc) - PH_W'(1);
  assign tick  = run && (phase_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     phase_q <= '0;
    else if (restart || !run || tick) phase_q <= '0;
    else                            phase_q <= phase_q + PH_W'(1);
  end

  assert_idle_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase_q == '0));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             ch_on,
  input  logic [CNT_W-1:0] lim_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match
);
  logic at_lim;

  assign at_lim = (cnt_q == lim_val);
  assign match  = tick && ch_on && (cnt_q == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (tick)  cnt_q <= at_lim ? '0 : cnt_q + CNT_W'(1);
  end

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt_q == lim_val) |=> (cnt_q == '0));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              match,
  output ctrl_t             ctrl,
  output chctl_t            chc,
  output logic [CNT_W-1:0]  lim_val,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              cnt_clr,
  output logic              flag,
  output logic              rsp_valid,
  output logic [CNT_W-1:0]  rsp_data
);
  logic wr, rd;
  logic hit_ctrl, hit_cnt, hit_lim, hit_stat, hit_chc, hit_chv;
  logic flag_clr;
  logic [CNT_W-1:0] rd_mux;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  assign hit_ctrl = (req_addr == ADDR_W'(OFS_CTRL));
  assign hit_cnt  = (req_addr == ADDR_W'(OFS_CNT));
  assign hit_lim  = (req_addr == ADDR_W'(OFS_LIM));
  assign hit_stat = (req_addr == ADDR_W'(OFS_STAT));
  assign hit_chc  = (req_addr == ADDR_W'(OFS_CHC));
  assign hit_chv  = (req_addr == ADDR_W'(OFS_CHV));

  assign cnt_clr  = wr && hit_cnt;
  assign flag_clr = wr && hit_stat && req_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      chc     <= '0;
      lim_val <= '0;
      cmp_val <= '0;
    end else if (wr) begin
      if (hit_ctrl) ctrl    <= ctrl_t'(req_wdata[CTRL_W-1:0]);
      if (hit_chc)  chc     <= chctl_t'(req_wdata[CHC_LSB +: CHC_W]);
      if (hit_lim)  lim_val <= req_wdata;
      if (hit_chv)  cmp_val <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (match)    flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux = CNT_W'(ctrl);
    if (hit_cnt)  rd_mux = cnt_val;
    if (hit_lim)  rd_mux = lim_val;
    if (hit_stat) rd_mux = CNT_W'(flag);
    if (hit_chc)  rd_mux = CNT_W'(chc) << CHC_LSB;
    if (hit_chv)  rd_mux = cmp_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_data  <= rd ? rd_mux : '0;
    end
  end

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  assert_flag_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match) |=> !flag);
  assert_rsp_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [CNT_W-1:0]  rsp_data,
  output logic              irq
);
  ctrl_t            ctrl;
  chctl_t           chc;
  logic [CNT_W-1:0] lim_val, cmp_val, cnt_val;
  logic             cnt_clr, flag, match, tick, run, ch_on;

  assign run   = (ctrl.clksel == CLKSEL_PRESCALED);
  assign ch_on = (chc.mode == CHMODE_SWCMP);
  assign irq   = flag && chc.irq_en;

  tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cnt_val(cnt_val), .match(match),
    .ctrl(ctrl), .chc(chc), .lim_val(lim_val), .cmp_val(cmp_val),
    .cnt_clr(cnt_clr), .flag(flag),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  tmr_prescale #(.EXP_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n),
    .run(run), .restart(cnt_clr), .psc(ctrl.psc), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tick(tick), .clr(cnt_clr), .ch_on(ch_on),
    .lim_val(lim_val), .cmp_val(cmp_val),
    .cnt_q(cnt_val), .match(match)
  );

  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> !irq);
  assert_no_tick_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, irq;
  logic [31:0] rsp_data;

  always #4 clk = ~clk;

  cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;

  // model state
  logic [4:0]  m_ctrl;
  logic [4:0]  m_chc;   // {ie, mode}
  logic [31:0] m_cnt, m_lim, m_chv;
  logic [6:0]  m_ph;
  logic        m_flag;
  logic        exp_pend;
  logic [31:0] exp_data;
  string       exp_tag;
  string       force_tag = "";

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h10: return "R4";
      8'h14: return "R5";
      8'h18: return "R5";
      8'h1C: return "R8";
      8'h20: return "R7";
      8'h24: return "R10";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h10: return {27'd0, m_ctrl};
      8'h14: return m_cnt;
      8'h18: return m_lim;
      8'h1C: return {31'd0, m_flag};
      8'h20: return {25'd0, m_chc, 2'b00};
      8'h24: return m_chv;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_chc = '0; m_cnt = '0; m_lim = '0; m_chv = '0;
      m_ph = '0; m_flag = 1'b0; exp_pend = 1'b0;
    end else begin
      logic en, tick, match, wr;
      logic [6:0] lim;
      en    = (m_ctrl[4:3] == 2'b01);
      lim   = (7'd1 << m_ctrl[2:0]) - 7'd1;
      tick  = en && (m_ph >= lim);
      match = tick && (m_chc[3:0] == 4'h4) && (m_cnt == m_chv);
      wr    = req_valid && req_write;
      exp_pend = req_valid && !req_write;
      if (exp_pend) begin
        exp_data = model_read(req_addr);
        exp_tag  = (force_tag != "") ? force_tag : tag_of(req_addr);
      end
      if (wr && req_addr == 8'h14) begin
        m_cnt = '0; m_ph = '0;
      end else begin
        if (!en || tick) m_ph = '0; else m_ph = m_ph + 7'd1;
        if (tick) m_cnt = (m_cnt == m_lim) ? 32'd0 : m_cnt + 32'd1;
      end
      if (match) m_flag = 1'b1;
      else if (wr && req_addr == 8'h1C && req_wdata[0]) m_flag = 1'b0;
      if (wr && req_addr == 8'h10) m_ctrl = req_wdata[4:0];
      if (wr && req_addr == 8'h18) m_lim  = req_wdata;
      if (wr && req_addr == 8'h20) m_chc  = req_wdata[6:2];
      if (wr && req_addr == 8'h24) m_chv  = req_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (irq !== (m_flag & m_chc[4])) begin
        n_bad++;
        $display("FAIL R9: irq=%b expected %b", irq, m_flag & m_chc[4]);
      end
      if (rsp_valid !== exp_pend) begin
        n_chk++; n_bad++;
        $display("FAIL R1: rsp_valid=%b expected %b", rsp_valid, exp_pend);
      end else if (exp_pend) begin
        n_chk++;
        if (rsp_data !== exp_data) begin
          n_bad++;
          $display("FAIL %s: rsp_data=%h expected %h", exp_tag, rsp_data, exp_data);
        end
      end
    end
  end

  task automatic put(input logic v, input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
  endtask
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d); put(1, 1, a, d); endtask
  task automatic rd_reg(input logic [7:0] a); put(1, 0, a, 32'd0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 0, 8'h00, 32'd0);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state of every register
    force_tag = "R2";
    foreach (u0.rsp_data[i]) if (i < 6) rd_reg(8'h10 + 8'(i * 4));
    idle(3);
    force_tag = "";
    // R4: divide by 8
    wr_reg(8'h18, 32'hFFFF_FFFF);
    wr_reg(8'h10, 32'h0000_000B);
    wr_reg(8'h14, 32'h1234_5678);  // R6 data ignored
    idle(16);
    rd_reg(8'h14);
    // R3: other clock select holds the count
    wr_reg(8'h10, 32'h0000_0018);
    idle(10);
    rd_reg(8'h14);
    // R8: set wins over clear; limit 0, value 0, every cycle matches
    wr_reg(8'h18, 32'd0);
    wr_reg(8'h24, 32'd0);
    wr_reg(8'h10, 32'h0000_0008);
    wr_reg(8'h20, 32'h0000_0050);
    idle(2);
    wr_reg(8'h1C, 32'd1);
    rd_reg(8'h1C);
    wr_reg(8'h14, 32'd0);          // R6 against a tick
    rd_reg(8'h14);
    // R7: non-compare mode stops matches; R8 write 0 no effect then clear
    wr_reg(8'h20, 32'h0000_0044);
    idle(2);
    wr_reg(8'h1C, 32'd0);
    rd_reg(8'h1C);
    wr_reg(8'h1C, 32'd1);
    rd_reg(8'h1C);
    // R10: value behind count, matches after wrap
    wr_reg(8'h18, 32'd20);
    wr_reg(8'h14, 32'd0);
    wr_reg(8'h20, 32'h0000_0050);
    idle(8);
    wr_reg(8'h24, 32'd3);
    rd_reg(8'h1C);
    idle(20);
    rd_reg(8'h1C);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int unsigned op;
      op = $urandom % 16;
      case (op)
        0: wr_reg(8'h10, {27'd0, (($urandom % 4 == 0) ? 2'($urandom) : 2'b01), 3'($urandom % 3)});
        1: wr_reg(8'h18, ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom % 24);
        2: wr_reg(8'h14, $urandom);
        3: wr_reg(8'h1C, $urandom);
        4: wr_reg(8'h20, ($urandom % 4 == 0) ? $urandom : {25'd0, 1'($urandom), 4'h4, 2'b00});
        5: wr_reg(8'h24, $urandom % 24);
        6, 7, 8, 9: begin
          logic [7:0] a;
          a = 8'(($urandom % 12) * 4);
          if ($urandom % 8 == 0) a = a + 8'd2;
          rd_reg(a);
        end
        default: idle(1);
      endcase
    end
    idle(4);
    finish_run();
  end
endmodule